// File: doc/BRIEF.md
# Two-Wire Serial Programming Master

This block drives the programming pins of a target microcontroller: a programming clock, a bidirectional data line split into output, output-enable and input, an active-low target reset line and a target power enable. A host issues one command at a time through a start strobe, a 2-bit operation code and a 24-bit instruction word. It waits for the one-cycle done pulse and, after a readback, takes the 16-bit result from the read-data output.

Four operations exist. Entry powers the target, pulses its reset line, shifts a 32-bit entry key with reset held low, then releases reset and waits for the target to settle. Execute sends a zero control prefix followed by a 24-bit instruction. The prefix is stretched to nine clocks on the first execute after an entry. Readback sends a four-bit prefix and eight idle clocks, then turns the data line around and clocks in a 16-bit word driven by the target. Exit drops power and reset at once. All timing comes from the system clock: a half-period divider for the programming clock and a wait counter for the entry delays.

Top module: `pgm2w_master`

## Requirements
- R1: After reset, busy, done, target power, target reset line, programming clock and data output are all 0, the data output enable is 1 and rd_data is 0.
- R2: An entry command (op 00) raises power in the first cycle after acceptance with reset low for PWR_WAIT cycles. Reset is then high for RST_PULSE cycles and low for RST_GAP cycles, then the key is shifted. After the key, reset goes high for ENTRY_SETTLE cycles before done.
- R3: The entry key is ENTRY_KEY, shifted most-significant bit first, 32 bits, with the target reset line low throughout.
- R4: Every bit lasts 2*HALF_DIV cycles: HALF_DIV with the programming clock high, then HALF_DIV with it low. Driven data changes only where the clock rises, so it is stable for a full half-period on both sides of each falling edge. The clock is low whenever the block is idle.
- R5: The first execute command (op 01) after an entry sends nine 0 prefix bits and then the 24-bit instruction least-significant bit first, 33 bits in total. The host must send a no-operation word in this frame.
- R6: Any other execute command sends four 0 prefix bits and then the instruction least-significant bit first, 28 bits in total.
- R7: A readback command (op 10) sends bits 0,0,0,1 then eight 0 bits. It then drops the data output enable for one half-period with the clock low. It clocks in 16 bits, least-significant first, each sampled where the clock falls. It raises the enable only after the last bit's low half, and the word appears on rd_data.
- R8: busy is high from the cycle after a command is accepted until the frame ends. done is high for exactly one cycle immediately after, with busy low.
- R9: A start strobe while busy is ignored: pins and timing continue unchanged and no extra frame follows.
- R10: An exit command (op 11) drops power and reset in the cycle after acceptance, finishes one cycle later, and cancels the stretched prefix. An execute with no entry since reset or exit uses the 4-bit prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | 00 entry, 01 execute, 10 readback, 11 exit |
| cmd_instr | input | 24 | Instruction word for execute |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word captured by the last readback |
| pg_clk | output | 1 | Programming clock |
| pg_dat_o | output | 1 | Data line output value |
| pg_dat_oe | output | 1 | Data line output enable |
| pg_dat_i | input | 1 | Data line input |
| tgt_rst_n | output | 1 | Target reset/enable line, active low |
| tgt_pwr_en | output | 1 | Target power enable |

## Verification
The bench builds the block with HALF_DIV=2 and entry waits of 5, 3, 4 and 6 cycles. With these values a complete entry takes under 150 cycles and every frame length can be compared cycle by cycle. The small divider also places the turnaround half-period and each sample point within a handful of cycles of a clock change. The bench exercises an execute before any entry, two entries with their stretched first frame, readback patterns with both end bits set, a strobe during a busy entry, and an exit followed by an execute.

// File: rtl/pgm2w_pkg.sv
// Shared constants and types for the two-wire programming master.
// Assumes frames never exceed FRAME_MAX bits and reads are READ_BITS wide.
package pgm2w_pkg;

    localparam int FRAME_MAX = 33;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int READ_BITS = 16;
    localparam int INSTR_W   = 24;
    localparam int KEY_BITS  = 32;

    typedef enum logic [1:0] {
        OP_ENTER = 2'b00,
        OP_EXEC  = 2'b01,
        OP_READ  = 2'b10,
        OP_EXIT  = 2'b11
    } pgm_op_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_TURN,
        SH_HIGH,
        SH_LOW
    } sh_state_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_PULSE,
        ST_GAP,
        ST_KEY,
        ST_SETTLE,
        ST_EXEC,
        ST_RPRE,
        ST_RDATA,
        ST_OFF
    } seq_state_e;

endpackage

// File: rtl/pgm2w_halfdiv.sv
// Half-period tick generator for the programming clock.
// Emits a one-cycle tick every HALF_DIV cycles while run is high; the phase
// restarts whenever run is low. Assumes HALF_DIV >= 1.
module pgm2w_halfdiv #(
    parameter int HALF_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    // Count system cycles inside the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pgm2w_delay.sv
// Down-counter for the entry waits. Loading value V-1 makes the
// expired flag appear V cycles after the load edge. Assumes one wait at a time.
module pgm2w_delay #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt == '0);

    // Load on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= value;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/pgm2w_shifter.sv
// Bit engine: shifts nbits of tx_vec (bit 0 first) with clock-high then
// clock-low halves, launching data where the clock rises. In receive mode it
// first releases the line for one low half-period, then samples sin where the
// clock falls, filling rx_word from the top (first bit ends up as bit 0).
// A start in the final tick of a frame chains the next frame seamlessly.
module pgm2w_shifter
    import pgm2w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 rx_en,
    input  logic [CNT_W-1:0]     nbits,
    input  logic [FRAME_MAX-1:0] tx_vec,
    input  logic                 sin,
    output logic                 active,
    output logic                 fin,
    output logic                 sclk,
    output logic                 sdat,
    output logic                 soe,
    output logic [READ_BITS-1:0] rx_word
);
    sh_state_e              state;
    logic [FRAME_MAX-1:0]   tx_sh;
    logic [CNT_W-1:0]       left;
    logic                   rx_mode;

    assign active = (state != SH_IDLE);
    assign fin    = tick && (state == SH_LOW) && (left == CNT_W'(1));
    assign sclk   = (state == SH_HIGH);
    assign sdat   = active && !rx_mode && tx_sh[0];
    assign soe    = !(active && rx_mode);

    // Bit sequencing: load, step half-periods, shift out and sample in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            tx_sh   <= '0;
            left    <= '0;
            rx_mode <= 1'b0;
            rx_word <= '0;
        end else if (start) begin
            rx_mode <= rx_en;
            tx_sh   <= tx_vec;
            left    <= nbits;
            state   <= rx_en ? SH_TURN : SH_HIGH;
        end else if (tick) begin
            case (state)
                SH_TURN: state <= SH_HIGH;
                SH_HIGH: begin
                    state <= SH_LOW;
                    if (rx_mode) begin
                        rx_word <= {sin, rx_word[READ_BITS-1:1]};
                    end
                end
                SH_LOW: begin
                    left  <= left - 1'b1;
                    tx_sh <= {1'b0, tx_sh[FRAME_MAX-1:1]};
                    state <= (left == CNT_W'(1)) ? SH_IDLE : SH_HIGH;
                end
                default: state <= SH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgm2w_master.sv
// Two-wire programming master: command sequencer over the bit engine, the
// half-period divider and the wait counter. Accepts one command when idle,
// ignores strobes while busy, and pulses done for one cycle at the end.
// Assumes every wait parameter and HALF_DIV is at least 1.
module pgm2w_master
    import pgm2w_pkg::*;
#(
    parameter int          HALF_DIV     = 13,
    parameter int          PWR_WAIT     = 12500,
    parameter int          RST_PULSE    = 125,
    parameter int          RST_GAP      = 125,
    parameter int          ENTRY_SETTLE = 6250,
    parameter logic [31:0] ENTRY_KEY    = 32'hC3A5_5A3C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_start,
    input  logic [1:0]  cmd_op,
    input  logic [23:0] cmd_instr,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        pg_clk,
    output logic        pg_dat_o,
    output logic        pg_dat_oe,
    input  logic        pg_dat_i,
    output logic        tgt_rst_n,
    output logic        tgt_pwr_en
);
    localparam int MAX_A   = (PWR_WAIT > RST_PULSE) ? PWR_WAIT : RST_PULSE;
    localparam int MAX_B   = (RST_GAP > ENTRY_SETTLE) ? RST_GAP : ENTRY_SETTLE;
    localparam int WAITMAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int DW      = $clog2(WAITMAX + 1);

    seq_state_e           state;
    logic                 first_pending;
    logic                 accept;
    pgm_op_e              op;

    logic                 sh_start, sh_rx, sh_fin, sh_active, tick;
    logic [CNT_W-1:0]     sh_nbits;
    logic [FRAME_MAX-1:0] sh_vec;
    logic                 dly_load, dly_exp;
    logic [DW-1:0]        dly_val;
    logic [KEY_BITS-1:0]  key_rev;

    // Key goes out most-significant bit first, so the engine sees it reversed.
    for (genvar i = 0; i < KEY_BITS; i++) begin : g_key_rev
        assign key_rev[i] = ENTRY_KEY[KEY_BITS-1-i];
    end

    assign op     = pgm_op_e'(cmd_op);
    assign accept = cmd_start && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    // Frame and wait requests issued on state transitions.
    always_comb begin
        sh_start = 1'b0;
        sh_rx    = 1'b0;
        sh_nbits = '0;
        sh_vec   = '0;
        dly_load = 1'b0;
        dly_val  = '0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (op)
                        OP_ENTER: begin
                            dly_load = 1'b1;
                            dly_val  = DW'(PWR_WAIT - 1);
                        end
                        OP_EXEC: begin
                            sh_start = 1'b1;
                            if (first_pending) begin
                                sh_nbits = CNT_W'(9 + INSTR_W);
                                sh_vec   = {cmd_instr, 9'b0};
                            end else begin
                                sh_nbits = CNT_W'(4 + INSTR_W);
                                sh_vec   = {5'b0, cmd_instr, 4'b0};
                            end
                        end
                        OP_READ: begin
                            sh_start = 1'b1;
                            sh_nbits = CNT_W'(12);
                            sh_vec   = FRAME_MAX'(8);
                        end
                        default: ;
                    endcase
                end
            end
            ST_PWR: begin
                dly_load = dly_exp;
                dly_val  = DW'(RST_PULSE - 1);
            end
            ST_PULSE: begin
                dly_load = dly_exp;
                dly_val  = DW'(RST_GAP - 1);
            end
            ST_GAP: begin
                sh_start = dly_exp;
                sh_nbits = CNT_W'(KEY_BITS);
                sh_vec   = {1'b0, key_rev};
            end
            ST_KEY: begin
                dly_load = sh_fin;
                dly_val  = DW'(ENTRY_SETTLE - 1);
            end
            ST_RPRE: begin
                sh_start = sh_fin;
                sh_rx    = 1'b1;
                sh_nbits = CNT_W'(READ_BITS);
            end
            default: ;
        endcase
    end

    // Command sequencer with target power, reset line and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            tgt_pwr_en    <= 1'b0;
            tgt_rst_n     <= 1'b0;
            first_pending <= 1'b0;
            done          <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (op)
                            OP_ENTER: begin
                                state         <= ST_PWR;
                                tgt_pwr_en    <= 1'b1;
                                tgt_rst_n     <= 1'b0;
                                first_pending <= 1'b0;
                            end
                            OP_EXEC: begin
                                state         <= ST_EXEC;
                                first_pending <= 1'b0;
                            end
                            OP_READ: state <= ST_RPRE;
                            default: begin
                                state         <= ST_OFF;
                                tgt_pwr_en    <= 1'b0;
                                tgt_rst_n     <= 1'b0;
                                first_pending <= 1'b0;
                            end
                        endcase
                    end
                end
                ST_PWR: begin
                    if (dly_exp) begin
                        state     <= ST_PULSE;
                        tgt_rst_n <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (dly_exp) begin
                        state     <= ST_GAP;
                        tgt_rst_n <= 1'b0;
                    end
                end
                ST_GAP: begin
                    if (dly_exp) state <= ST_KEY;
                end
                ST_KEY: begin
                    if (sh_fin) begin
                        state     <= ST_SETTLE;
                        tgt_rst_n <= 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (dly_exp) begin
                        state         <= ST_IDLE;
                        done          <= 1'b1;
                        first_pending <= 1'b1;
                    end
                end
                ST_EXEC, ST_RDATA: begin
                    if (sh_fin) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                ST_RPRE: begin
                    if (sh_fin) state <= ST_RDATA;
                end
                ST_OFF: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    pgm2w_halfdiv #(.HALF_DIV(HALF_DIV)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .tick  (tick)
    );

    pgm2w_delay #(.W(DW)) i_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dly_load),
        .value   (dly_val),
        .expired (dly_exp)
    );

    pgm2w_shifter i_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (sh_start),
        .rx_en   (sh_rx),
        .nbits   (sh_nbits),
        .tx_vec  (sh_vec),
        .sin     (pg_dat_i),
        .active  (sh_active),
        .fin     (sh_fin),
        .sclk    (pg_clk),
        .sdat    (pg_dat_o),
        .soe     (pg_dat_oe),
        .rx_word (rd_data)
    );
endmodule

// File: rtl/pgm2w_master_chk.sv
// Port-level protocol checker for pgm2w_master, attached by bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module pgm2w_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic pg_clk,
    input logic pg_dat_o,
    input logic pg_dat_oe,
    input logic tgt_rst_n,
    input logic tgt_pwr_en
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                   // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                   // R8
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pg_clk && pg_dat_oe));                 // R4
    AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_clk) |-> $stable(pg_dat_o));              // R4
    AST_RST_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst_n |-> tgt_pwr_en);                         // R2
    AST_RELEASE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_dat_oe) |-> !pg_clk);                     // R7
endmodule

bind pgm2w_master pgm2w_master_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .pg_clk     (pg_clk),
    .pg_dat_o   (pg_dat_o),
    .pg_dat_oe  (pg_dat_oe),
    .tgt_rst_n  (tgt_rst_n),
    .tgt_pwr_en (tgt_pwr_en)
);

// File: tb/test_pgm2w_master.sv
// Bench: a behavioural per-cycle model (queue of expected pin states) built
// from the requirements, compared against the design at every falling edge.
module test_pgm2w_master;
    localparam int          HD  = 2;
    localparam int          PW  = 5;
    localparam int          PL  = 3;
    localparam int          GP  = 4;
    localparam int          STL = 6;
    localparam logic [31:0] KEY = 32'h9E37_4C1B;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_start;
    logic [1:0]  cmd_op;
    logic [23:0] cmd_instr;
    logic        busy, done, pg_clk, pg_dat_o, pg_dat_oe, pg_dat_i;
    logic        tgt_rst_n, tgt_pwr_en;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    pgm2w_master #(
        .HALF_DIV(HD), .PWR_WAIT(PW), .RST_PULSE(PL), .RST_GAP(GP),
        .ENTRY_SETTLE(STL), .ENTRY_KEY(KEY)
    ) i_pgm2w_master (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_instr(cmd_instr), .busy(busy), .done(done), .rd_data(rd_data),
        .pg_clk(pg_clk), .pg_dat_o(pg_dat_o), .pg_dat_oe(pg_dat_oe),
        .pg_dat_i(pg_dat_i), .tgt_rst_n(tgt_rst_n), .tgt_pwr_en(tgt_pwr_en)
    );

    typedef struct packed {
        logic        busy, done, pwr, rst, sclk, dat, oe, chk;
        logic [15:0] rd;
        logic [7:0]  req;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    logic        m_pwr = 1'b0, m_rst = 1'b0, m_first = 1'b0;
    logic [15:0] tgt_word = '0;
    int          tgt_idx = 0;
    logic        prev_clk = 1'b0;
    bit          finished = 1'b0;

    task automatic push(input logic c, input logic d, input logic oe,
                        input int n, input int req);
        for (int i = 0; i < n; i++) begin
            q.push_back('{busy:1'b1, done:1'b0, pwr:m_pwr, rst:m_rst, sclk:c,
                          dat:d, oe:oe, chk:1'b0, rd:16'h0, req:8'(req)});
        end
    endtask

    task automatic push_bit(input logic b, input int req);
        push(1'b1, b, 1'b1, HD, req);
        push(1'b0, b, 1'b1, HD, req);
    endtask

    // R8: done for one cycle right after the last busy cycle.
    task automatic push_done(input logic chk, input logic [15:0] rd, input int req);
        q.push_back('{busy:1'b0, done:1'b1, pwr:m_pwr, rst:m_rst, sclk:1'b0,
                      dat:1'b0, oe:1'b1, chk:chk, rd:rd, req:8'(req)});
    endtask

    task automatic model_cmd(input logic [1:0] op, input logic [23:0] ins);
        case (op)
            2'b00: begin // R2 entry, R3 key
                m_pwr = 1'b1; m_rst = 1'b0; push(1'b0, 1'b0, 1'b1, PW, 2);
                m_rst = 1'b1;               push(1'b0, 1'b0, 1'b1, PL, 2);
                m_rst = 1'b0;               push(1'b0, 1'b0, 1'b1, GP, 2);
                for (int i = 31; i >= 0; i--) push_bit(KEY[i], 3);
                m_rst = 1'b1;               push(1'b0, 1'b0, 1'b1, STL, 2);
                push_done(1'b0, 16'h0, 8);
                m_first = 1'b1;
            end
            2'b01: begin // R5 first execute, R6 later execute
                if (m_first) begin
                    for (int i = 0; i < 9; i++) push_bit(1'b0, 5);
                    for (int i = 0; i < 24; i++) push_bit(ins[i], 5);
                end else begin
                    for (int i = 0; i < 4; i++) push_bit(1'b0, 6);
                    for (int i = 0; i < 24; i++) push_bit(ins[i], 6);
                end
                m_first = 1'b0;
                push_done(1'b0, 16'h0, 8);
            end
            2'b10: begin // R7 readback
                push_bit(1'b0, 7); push_bit(1'b0, 7); push_bit(1'b0, 7); push_bit(1'b1, 7);
                for (int i = 0; i < 8; i++) push_bit(1'b0, 7);
                push(1'b0, 1'b0, 1'b0, HD, 7);
                for (int i = 0; i < 16; i++) begin
                    push(1'b1, 1'b0, 1'b0, HD, 7);
                    push(1'b0, 1'b0, 1'b0, HD, 7);
                end
                push_done(1'b1, tgt_word, 7);
            end
            default: begin // R10 exit
                m_pwr = 1'b0; m_rst = 1'b0; m_first = 1'b0;
                push(1'b0, 1'b0, 1'b1, 1, 10);
                push_done(1'b0, 16'h0, 10);
            end
        endcase
    endtask

    // One system cycle: compare at the falling edge, then act as the target.
    task automatic cycle();
        exp_t e;
        @(negedge clk);
        if (q.size() > 0) e = q.pop_front();
        else e = '{busy:1'b0, done:1'b0, pwr:m_pwr, rst:m_rst, sclk:1'b0,
                   dat:1'b0, oe:1'b1, chk:1'b0, rd:16'h0, req:8'd8};
        checks++;
        if ({busy, done, tgt_pwr_en, tgt_rst_n, pg_clk, pg_dat_o, pg_dat_oe} !==
            {e.busy, e.done, e.pwr, e.rst, e.sclk, e.dat, e.oe}) begin
            errors++;
            $display("FAIL R%0d pins busy,done,pwr,rst,clk,dat,oe got %b%b%b%b%b%b%b expected %b%b%b%b%b%b%b at %0t",
                     e.req, busy, done, tgt_pwr_en, tgt_rst_n, pg_clk, pg_dat_o, pg_dat_oe,
                     e.busy, e.done, e.pwr, e.rst, e.sclk, e.dat, e.oe, $time);
        end
        if (e.chk) begin
            checks++;
            if (rd_data !== e.rd) begin
                errors++;
                $display("FAIL R7 rd_data got %h expected %h", rd_data, e.rd);
            end
        end
        if (!pg_dat_oe && pg_clk && !prev_clk && tgt_idx < 16) begin
            pg_dat_i = tgt_word[tgt_idx];
            tgt_idx++;
        end
        prev_clk = pg_clk;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [23:0] ins);
        cycle();
        cmd_start = 1'b1; cmd_op = op; cmd_instr = ins;
        if (q.size() == 0) model_cmd(op, ins); // R9: strobes while busy add nothing
        cycle();
        cmd_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) cycle();
        cycle();
    endtask

    task automatic read_word(input logic [15:0] w);
        tgt_word = w; tgt_idx = 0;
        cmd(2'b10, 24'h0);
        wait_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog got no completion expected end of run");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_start = 1'b0; cmd_op = 2'b00; cmd_instr = '0; pg_dat_i = 1'b0;
        repeat (3) cycle();
        // R1: reset state, including the read register
        checks++;
        if ({busy, done, tgt_pwr_en, tgt_rst_n, pg_clk, pg_dat_o, pg_dat_oe, rd_data} !==
            {7'b0000001, 16'h0}) begin
            errors++;
            $display("FAIL R1 reset got %b%b%b%b%b%b%b %h expected 0000001 0000",
                     busy, done, tgt_pwr_en, tgt_rst_n, pg_clk, pg_dat_o, pg_dat_oe, rd_data);
        end
        rst_n = 1'b1;
        repeat (3) cycle();

        cmd(2'b01, 24'h3C5A96);   // R10: execute before any entry uses 4-bit prefix
        wait_idle();
        cmd(2'b00, 24'h0);        // R2, R3
        repeat (10) cycle();
        cmd(2'b10, 24'h0);        // R9: readback strobe during entry is ignored
        wait_idle();
        cmd(2'b01, 24'h000000);   // R5: stretched prefix, no-operation word
        wait_idle();
        cmd(2'b01, 24'hA5C3F1);   // R6
        wait_idle();
        read_word(16'hB38D);      // R7
        read_word(16'h8001);      // R7: both end bits set
        cmd(2'b01, 24'h800001);   // R6: both end bits of the instruction
        cmd(2'b01, 24'hFFFFFF);   // R9: ignored, previous frame still running
        wait_idle();
        cmd(2'b00, 24'h0);        // R2: second entry
        wait_idle();
        cmd(2'b11, 24'h0);        // R10: exit right after entry cancels stretched prefix
        wait_idle();
        cmd(2'b01, 24'h0F0F0F);   // R10: 4-bit prefix after exit
        wait_idle();
        cmd(2'b00, 24'h0);
        wait_idle();
        cmd(2'b01, 24'h000000);   // R5 again after re-entry
        wait_idle();
        read_word(16'h0000);      // R7
        repeat (4) cycle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule